// File: doc/BRIEF.md
# Serial Flash Sector Erase Sequencer

This block sits on the host side of a serial flash bus and erases one 4 KB sector on its own once it is told to. A one-cycle `start` pulse presents a 24-bit byte address. The block keeps only the sector part of that address. It then runs a fixed series of chip-select frames:

- a write-enable command;
- the erase command with its three address bytes;
- repeated status reads, until the device reports it is no longer busy.

A one-cycle `done` pulse reports that the erase is complete. A one-cycle `timeout` pulse reports instead that the poll budget ran out.

The serial clock comes from the system clock through a parameterised divider. The bus uses SPI mode 0: SCK rests low, and both ends sample on the rising edge. Chip select rises after the last clock of the erase frame, which is what makes the device start its self-timed erase. Between frames, chip select is held high for at least two SCK periods.

Top module: `sector_erase_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `cs_n` is 1, `sck` is 0, and `done` and `timeout` are 0 until a start is accepted.
- R2: The first frame of an operation is 8 SCK clocks long and carries the write-enable opcode 06h, most significant bit first.
- R3: The second frame is 32 SCK clocks long. It carries opcode 20h followed by the address, bit 23 first, with address bits 11 down to 0 sent as zero.
- R4: Every frame has its own chip-select-low interval. Each poll frame is 16 clocks long: opcode 05h followed by 8 clocks in which a status byte is read. Chip select stays high for at least 4*HALF_DIV system cycles before each falling edge.
- R5: SCK is low whenever chip select is high, and `mosi` does not change while SCK is high.
- R6: `miso` is sampled on each rising SCK edge. Status bit 0 is the busy flag. Polling repeats while it reads 1. When it reads 0, `done` pulses and no further frame is sent.
- R7: If MAX_POLLS consecutive poll frames all read busy, `timeout` pulses instead of `done` and the block returns to idle.
- R8: A `start` pulse while an operation is in progress is ignored. It causes no extra frames and does not change the erase address.
- R9: `done` and `timeout` are each high for exactly one cycle per operation and are never high together.
- R10: Each SCK high phase, and each low phase inside a frame, lasts exactly HALF_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to erase a sector |
| sector_addr | input | 24 | Byte address inside the sector to erase |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| done | output | 1 | One-cycle pulse: erase finished |
| timeout | output | 1 | One-cycle pulse: busy never cleared |

## Verification
The bench contains a behavioural flash that holds busy for a set number of polls. That number is swept from zero to past the poll budget, at corner and mixed addresses. The swept busy counts separate an exit on the first poll, an exit on the last allowed poll, and a timeout one poll early or one poll late. The all-ones address shows whether the low twelve bits are really cleared. The status byte also has bit 1 set, which shows whether the block tests only bit 0. A second start in the middle of an operation, with a different address, shows whether the request is latched only once.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;
  localparam logic [7:0] OP_WR_EN   = 8'h06;
  localparam logic [7:0] OP_SEC_ERS = 8'h20;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam int FRAME_W    = 32;
  localparam int ADDR_W     = 24;
  localparam int SECTOR_LSB = 12;
  localparam int CNT_W      = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    FR_IDLE, FR_LO, FR_HI, FR_TAIL, FR_GAP
  } frm_st_t;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_WREN, SQ_ERASE, SQ_POLL
  } seq_st_t;
endpackage

// File: rtl/sck_tick_gen.sv
module sck_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    if (!en || cnt_q == LAST) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import sec_erase_pkg::*;
#(
  parameter int GAP_HALVES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               go,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [CNT_W-1:0]   n_bits,
  input  logic               miso,
  output logic               active,
  output logic               frame_done,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi,
  output logic [7:0]         rx_byte
);
  localparam int GW = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  frm_st_t            st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [GW-1:0]      gap_q, gap_d;
  logic               sck_q, sck_d, cs_q, cs_d, done_q, done_d;
  logic [7:0]         rx_q, rx_d;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    left_d = left_q;
    gap_d  = gap_q;
    sck_d  = sck_q;
    cs_d   = cs_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    case (st_q)
      FR_IDLE: if (go) begin
        sh_d   = tx_word;
        left_d = n_bits;
        cs_d   = 1'b0;
        st_d   = FR_LO;
      end
      FR_LO: if (tick) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
        st_d  = FR_HI;
      end
      FR_HI: if (tick) begin
        sck_d  = 1'b0;
        left_d = left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          st_d = FR_TAIL;
        end else begin
          sh_d = {sh_q[FRAME_W-2:0], 1'b0};
          st_d = FR_LO;
        end
      end
      FR_TAIL: if (tick) begin
        cs_d  = 1'b1;
        gap_d = GW'(GAP_HALVES - 1);
        st_d  = FR_GAP;
      end
      FR_GAP: if (tick) begin
        if (gap_q == '0) begin
          st_d   = FR_IDLE;
          done_d = 1'b1;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      gap_q  <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      gap_q  <= gap_d;
      sck_q  <= sck_d;
      cs_q   <= cs_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign active     = (st_q != FR_IDLE);
  assign frame_done = done_q;
  assign sck        = sck_q;
  assign cs_n       = cs_q;
  assign mosi       = sh_q[FRAME_W-1];
  assign rx_byte    = rx_q;
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import sec_erase_pkg::*;
#(
  parameter int MAX_POLLS = 65536
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               frame_done,
  input  logic [7:0]         rx_byte,
  output logic               go,
  output logic [FRAME_W-1:0] tx_word,
  output logic [CNT_W-1:0]   n_bits,
  output logic               done,
  output logic               timeout
);
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);
  localparam logic [FRAME_W-1:0] POLL_WORD = {OP_STATUS, 24'h000000};

  seq_st_t           st_q, st_d;
  logic [ADDR_W-1:0] sec_q, sec_d;
  logic [PW-1:0]     pc_q, pc_d;
  logic              done_q, done_d, to_q, to_d;

  always_comb begin
    st_d    = st_q;
    sec_d   = sec_q;
    pc_d    = pc_q;
    go      = 1'b0;
    tx_word = '0;
    n_bits  = '0;
    done_d  = 1'b0;
    to_d    = 1'b0;
    case (st_q)
      SQ_IDLE: if (start) begin
        sec_d   = (addr >> SECTOR_LSB) << SECTOR_LSB;
        pc_d    = '0;
        go      = 1'b1;
        tx_word = {OP_WR_EN, 24'h000000};
        n_bits  = CNT_W'(8);
        st_d    = SQ_WREN;
      end
      SQ_WREN: if (frame_done) begin
        go      = 1'b1;
        tx_word = {OP_SEC_ERS, sec_q};
        n_bits  = CNT_W'(32);
        st_d    = SQ_ERASE;
      end
      SQ_ERASE: if (frame_done) begin
        go      = 1'b1;
        tx_word = POLL_WORD;
        n_bits  = CNT_W'(16);
        st_d    = SQ_POLL;
      end
      SQ_POLL: if (frame_done) begin
        if (!rx_byte[0]) begin
          done_d = 1'b1;
          st_d   = SQ_IDLE;
        end else if (pc_q == LAST_POLL) begin
          to_d = 1'b1;
          st_d = SQ_IDLE;
        end else begin
          pc_d    = pc_q + 1'b1;
          go      = 1'b1;
          tx_word = POLL_WORD;
          n_bits  = CNT_W'(16);
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      sec_q  <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sec_q  <= sec_d;
      pc_q   <= pc_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  assign done    = done_q;
  assign timeout = to_q;
endmodule

// File: rtl/sector_erase_ctl.sv
module sector_erase_ctl
  import sec_erase_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int MAX_POLLS = 65536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] sector_addr,
  input  logic        miso,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  output logic        done,
  output logic        timeout
);
  localparam int GAP_HALVES = 4;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic               tick, active, frame_done, go;
  logic [FRAME_W-1:0] tx_word;
  logic [CNT_W-1:0]   n_bits;
  logic [7:0]         rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sck_tick_gen #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .en   (active),
    .tick (tick)
  );

  spi_frame_engine #(.GAP_HALVES(GAP_HALVES)) u_frm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .go        (go),
    .tx_word   (tx_word),
    .n_bits    (n_bits),
    .miso      (miso),
    .active    (active),
    .frame_done(frame_done),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .rx_byte   (rx_byte)
  );

  erase_seq #(.MAX_POLLS(MAX_POLLS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .addr      (sector_addr),
    .frame_done(frame_done),
    .rx_byte   (rx_byte),
    .go        (go),
    .tx_word   (tx_word),
    .n_bits    (n_bits),
    .done      (done),
    .timeout   (timeout)
  );
endmodule

// File: rtl/sec_erase_chk.sv
module sec_erase_chk #(
  parameter int GAP_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic done,
  input logic timeout
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hi_cnt <= 16'(GAP_CYC);
    else if (!cs_n)                  hi_cnt <= '0;
    else if (hi_cnt < 16'(GAP_CYC))  hi_cnt <= hi_cnt + 1'b1;
  end

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R4
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 16'(GAP_CYC)));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !timeout);

  // R9
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  to_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
endmodule

bind sector_erase_ctl sec_erase_chk #(.GAP_CYC(4 * HALF_DIV)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sck    (sck),
  .cs_n   (cs_n),
  .mosi   (mosi),
  .done   (done),
  .timeout(timeout)
);

// File: tb/sim_sector_erase_ctl.sv
`timescale 1ns/1ps
module sim_sector_erase_ctl;
  localparam int HD = 2;
  localparam int MP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] sector_addr = '0;
  logic        miso = 1'b0;
  logic        sck, cs_n, mosi, done, timeout;

  always #2.5 clk = ~clk;

  sector_erase_ctl #(.HALF_DIV(HD), .MAX_POLLS(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sector_addr(sector_addr),
    .miso(miso), .sck(sck), .cs_n(cs_n), .mosi(mosi), .done(done), .timeout(timeout)
  );

  int n_chk = 0;
  int n_fail = 0;
  int busy_cfg = 0;

  // flash model
  logic [63:0] cap = '0;
  int          nb = 0;
  logic        rd_mode = 1'b0;
  logic [7:0]  stat_q = '0;
  int          polls_seen = 0;
  int          f_cnt = 0;
  int          total_frames = 0;
  logic [31:0] f_val [0:15];
  int          f_bits [0:15];

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      if (nb > 0) begin
        if (nb == 8 && cap[7:0] == 8'h06) begin
          f_cnt = 0;
          polls_seen = 0;
        end
        if (f_cnt < 16) begin
          f_val[f_cnt]  = cap[31:0];
          f_bits[f_cnt] = nb;
        end
        f_cnt++;
        total_frames++;
        if (rd_mode) polls_seen++;
      end
      cap = '0;
      nb = 0;
      rd_mode = 1'b0;
    end else begin
      cap = {cap[62:0], mosi};
      nb++;
      if (nb == 8 && cap[7:0] == 8'h05) begin
        rd_mode = 1'b1;
        stat_q = {6'b0, 1'b1, (polls_seen < busy_cfg)};
      end
    end
  end

  always @(negedge sck) begin
    if (rd_mode && nb >= 8 && nb < 16) miso = stat_q[15 - nb];
    else                               miso = 1'b0;
  end

  // monitors
  int done_cnt = 0, to_cnt = 0, both_cnt = 0, dbl_cnt = 0;
  logic done_p = 1'b0, to_p = 1'b0;
  int hi_run = 0, lo_run = 0, cs_hi_run = 1000;
  int hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0, gap_min = 1000;
  int mosi_bad = 0;
  logic mosi_at_hi = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (timeout) to_cnt++;
      if (done && timeout) both_cnt++;
      if ((done && done_p) || (timeout && to_p)) dbl_cnt++;
      done_p = done;
      to_p = timeout;
      if (sck) begin
        if (hi_run == 0) mosi_at_hi = mosi;
        else if (mosi != mosi_at_hi) mosi_bad++;
        hi_run++;
        if (lo_run > 0) begin
          if (lo_run < lo_min) lo_min = lo_run;
          if (lo_run > lo_max) lo_max = lo_run;
        end
        lo_run = 0;
      end else begin
        if (hi_run > 0) begin
          if (hi_run < hi_min) hi_min = hi_run;
          if (hi_run > hi_max) hi_max = hi_run;
        end
        hi_run = 0;
        if (!cs_n) lo_run++;
        else       lo_run = 0;
      end
      if (cs_n) cs_hi_run++;
      else begin
        if (cs_hi_run > 0 && cs_hi_run < gap_min) gap_min = cs_hi_run;
        cs_hi_run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [23:0] a, input int busy_n, input bit poke);
    int d0, t0, tf, polls, cyc;
    bit exp_done;
    busy_cfg = busy_n;
    d0 = done_cnt;
    t0 = to_cnt;
    @(negedge clk);
    start = 1'b1;
    sector_addr = a;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (done_cnt == d0 && to_cnt == t0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin
        start = 1'b1;
        sector_addr = ~a;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(cyc < 20000, "R6 watchdog", 64'(cyc), 64'd20000);
    exp_done = (busy_n < MP);
    polls = exp_done ? busy_n + 1 : MP;
    // R6 R7
    chk((done_cnt - d0) == int'(exp_done), "R6 done pulse", 64'(done_cnt - d0), 64'(exp_done));
    chk((to_cnt - t0) == int'(!exp_done), "R7 timeout pulse", 64'(to_cnt - t0), 64'(!exp_done));
    // R4 R8
    chk(f_cnt == 2 + polls, "R4 frame count", 64'(f_cnt), 64'(2 + polls));
    // R2
    chk(f_bits[0] == 8 && f_val[0][7:0] == 8'h06, "R2 write-enable frame",
        {32'(f_bits[0]), f_val[0]}, {32'd8, 32'h06});
    // R3 R8
    chk(f_bits[1] == 32 && f_val[1] == {8'h20, a[23:12], 12'h000}, "R3 erase frame",
        {32'(f_bits[1]), f_val[1]}, {32'd32, 8'h20, a[23:12], 12'h000});
    for (int i = 2; i < 2 + polls && i < 16; i++) begin
      chk(f_bits[i] == 16 && f_val[i][15:8] == 8'h05, "R4 poll frame",
          {32'(f_bits[i]), 16'h0, f_val[i][15:0]}, {32'd16, 16'h0, 8'h05, 8'h00});
    end
    tf = total_frames;
    repeat (200) @(negedge clk);
    // R6 R9
    chk(total_frames == tf, "R6 no frame after end", 64'(total_frames), 64'(tf));
    chk(done_cnt - d0 + to_cnt - t0 == 1, "R9 one pulse per op",
        64'(done_cnt - d0 + to_cnt - t0), 64'd1);
  endtask

  initial begin
    logic [23:0] addrs [0:3];
    addrs[0] = 24'h000000;
    addrs[1] = 24'hFFFFFF;
    addrs[2] = 24'hABCDEF;
    addrs[3] = 24'h5A5123;
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n == 1'b1 && sck == 1'b0 && done == 1'b0 && timeout == 1'b0, "R1 in reset",
        {cs_n, sck, done, timeout}, 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0 && done == 1'b0 && timeout == 1'b0, "R1 after reset",
        {cs_n, sck, done, timeout}, 4'b1000);
    for (int ai = 0; ai < 4; ai++) begin
      for (int b = 0; b <= MP + 1; b++) begin
        run_op(addrs[ai], b, 1'b0);
      end
    end
    // R8: second start mid-operation with another address
    run_op(24'h123456, 2, 1'b1);
    run_op(24'h876FFF, MP, 1'b1);
    // R10
    chk(hi_min == HD && hi_max == HD, "R10 sck high phase", {32'(hi_min), 32'(hi_max)},
        {32'(HD), 32'(HD)});
    chk(lo_min == HD && lo_max == HD, "R10 sck low phase", {32'(lo_min), 32'(lo_max)},
        {32'(HD), 32'(HD)});
    // R4
    chk(gap_min >= 4 * HD, "R4 chip-select gap", 64'(gap_min), 64'(4 * HD));
    // R5
    chk(mosi_bad == 0, "R5 mosi stable while sck high", 64'(mosi_bad), 64'd0);
    // R9
    chk(both_cnt == 0 && dbl_cnt == 0, "R9 pulse shape", {32'(both_cnt), 32'(dbl_cnt)}, 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule